// File: doc/BRIEF.md
# Adjacent-Pixel Proton-Electron Coincidence Unit

This block pairs proton hits with electron hits on a hexagonal pixel array of 127 pixels per plane. Protons arrive on one valid/ready stream, from the upper plane only. Electrons arrive on a second stream, tagged with the plane they hit (top or bottom). Every event carries a pixel number and a timestamp in 100 MHz sample ticks. Each accepted proton stays open in a small ordered list for a programmable window, 4000 ticks (40 us) by default.

An electron pairs with an open proton when two conditions hold. The electron pixel is the proton pixel itself or one of the six neighbours held for the electron pixel in a loadable table. The electron is not earlier than the proton and is no later than the window allows. A pair leaves the block on a valid/ready output stream carrying both pixel numbers, the electron plane and the tick difference.

Back-pressure rules: the proton stream never stalls, and a proton that arrives while the list is full is dropped and counted. The electron stream stalls only while a result is held and the output is not ready. Output fields stay frozen while valid is high and ready is low. Counters report pairs found, open protons that aged out unmatched, and dropped protons.

Top module: `pe_coinc_top`

## Requirements
- R1: `p_ready` is always high. An accepted proton is opened when fewer than DEPTH (default 4) protons are open. At most DEPTH protons are open at any time.
- R2: A proton accepted while DEPTH protons are open is discarded and `n_dropped` increments by one. The discarded proton never pairs.
- R3: An electron pairs with an open proton when two conditions hold. First, the electron pixel equals the proton pixel, or the proton pixel appears in one of the electron pixel's six table slots. Second, 0 <= e_time - p_time <= `win_ticks`, computed modulo 2^32 with both ends inclusive. The electron plane (`e_plane` 0 = top, 1 = bottom) does not affect pairing.
- R4: When several open protons qualify, the one opened earliest is paired. That proton is closed and cannot pair again.
- R5: One cycle after an electron is accepted and paired, `c_valid` is high. `c_p_pixel` holds the proton pixel, `c_e_pixel` and `c_e_plane` hold the electron's pixel and plane, and `c_dt` holds e_time - p_time.
- R6: While `c_valid` is high and `c_ready` is low, the output fields hold and `e_ready` is low. Otherwise `e_ready` is high.
- R7: An accepted electron that pairs with nothing produces no output and leaves the open protons unchanged.
- R8: The oldest open proton is closed without a pair, and `n_expired` increments, in the cycle where `cur_time` - p_time > `win_ticks`. Equality keeps it open. An electron pairing in the same cycle defers the expiry by one cycle.
- R9: A cycle with `tbl_we` high writes `tbl_nbr` into slot `tbl_slot` (0..5) of pixel `tbl_pixel` (0..126). A pixel or slot outside those ranges is ignored. Reset fills every slot with 127, the empty code, which matches nothing.
- R10: `n_coinc` increments once for every pair produced.
- R11: After reset, no proton is open, `c_valid` is low and all counters are zero.
- R12: An electron is compared only against protons opened in earlier cycles. A proton accepted in the same cycle is not visible to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_time | input | 32 | Current tick count, used for expiry |
| win_ticks | input | 16 | Coincidence window in ticks |
| p_valid | input | 1 | Proton event valid |
| p_ready | output | 1 | Proton stream ready (always high) |
| p_pixel | input | 7 | Proton pixel number |
| p_time | input | 32 | Proton timestamp |
| e_valid | input | 1 | Electron event valid |
| e_ready | output | 1 | Electron stream ready |
| e_pixel | input | 7 | Electron pixel number |
| e_plane | input | 1 | Electron plane, 0 top, 1 bottom |
| e_time | input | 32 | Electron timestamp |
| tbl_we | input | 1 | Neighbour table write strobe |
| tbl_pixel | input | 7 | Pixel whose row is written |
| tbl_slot | input | 3 | Neighbour slot 0..5 |
| tbl_nbr | input | 7 | Neighbour pixel number, 127 = empty |
| c_valid | output | 1 | Coincidence result valid |
| c_ready | input | 1 | Downstream ready for the result |
| c_p_pixel | output | 7 | Paired proton pixel |
| c_e_pixel | output | 7 | Paired electron pixel |
| c_e_plane | output | 1 | Paired electron plane |
| c_dt | output | 32 | Electron time minus proton time |
| n_coinc | output | 16 | Pairs produced |
| n_expired | output | 16 | Protons closed unmatched by age |
| n_dropped | output | 16 | Protons lost to a full list |

## Verification
A corrupted open list shows up at the ports on the next paired electron, in one of three ways. The wrong `c_dt` or `c_p_pixel` may appear, because the wrong entry was taken as oldest. A closed proton may pair a second time. A live proton may fail to pair. A bad head timestamp or occupancy count shows up within one cycle as an early or missing `n_expired` step, or as an early `n_dropped` step. The tests place electrons exactly on and one tick past the window edges, feed the list until it is full, and feed a proton and an electron in the same cycle. A fault in any one of these areas then shows in one result or counter value.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int PIX_W    = 7;
  localparam int NPIX     = 127;
  localparam int NNBR     = 6;
  localparam int SLOT_W   = $clog2(NNBR + 1);
  localparam int TS_W     = 32;
  localparam int WIN_W    = 16;
  localparam logic [PIX_W-1:0] PIX_NONE = '1;

  typedef logic [PIX_W-1:0] pix_t;
  typedef logic [TS_W-1:0]  ts_t;

  typedef struct packed {
    pix_t pix;
    ts_t  ts;
  } popen_t;
endpackage

// File: rtl/pe_nbr_table.sv
module pe_nbr_table
  import pe_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  pix_t                        wr_pix,
  input  logic [SLOT_W-1:0]           wr_slot,
  input  pix_t                        wr_val,
  input  pix_t                        rd_pix,
  output logic [NNBR-1:0][PIX_W-1:0]  rd_nbrs
);
  logic [NNBR-1:0][PIX_W-1:0] rows [NPIX];
  logic wr_ok;

  assign wr_ok = wr_en && (wr_pix < PIX_W'(NPIX)) && (wr_slot < SLOT_W'(NNBR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPIX; p++) rows[p] <= {NNBR{PIX_NONE}};
    end else if (wr_ok) begin
      rows[wr_pix][wr_slot] <= wr_val;
    end
  end

  always_comb begin
    if (rd_pix < PIX_W'(NPIX)) rd_nbrs = rows[rd_pix];
    else                       rd_nbrs = {NNBR{PIX_NONE}};
  end
endmodule

// File: rtl/pe_match_unit.sv
module pe_match_unit
  import pe_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IDX_W = 2
) (
  input  popen_t [DEPTH-1:0]          ents,
  input  logic   [DEPTH-1:0]          vld,
  input  pix_t                        e_pix,
  input  ts_t                         e_ts,
  input  logic [NNBR-1:0][PIX_W-1:0]  nbrs,
  input  logic [WIN_W-1:0]            window,
  output logic                        hit_any,
  output logic [IDX_W-1:0]            hit_idx,
  output ts_t                         hit_dt,
  output pix_t                        hit_pix
);
  ts_t        dt  [DEPTH];
  logic [DEPTH-1:0] hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic nb_ok;
    always_comb begin
      nb_ok = 1'b0;
      for (int j = 0; j < NNBR; j++) begin
        if (nbrs[j] != PIX_NONE && nbrs[j] == ents[i].pix) nb_ok = 1'b1;
      end
    end
    assign dt[i]  = e_ts - ents[i].ts;
    assign hit[i] = vld[i] && (dt[i] <= TS_W'(window)) &&
                    ((ents[i].pix == e_pix) || nb_ok);
  end

  // lowest index is the oldest open proton
  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit[i]) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  assign hit_dt  = dt[hit_idx];
  assign hit_pix = ents[hit_idx].pix;
endmodule

// File: rtl/pe_open_list.sv
module pe_open_list
  import pe_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IDX_W = 2,
  parameter int OCC_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  popen_t              push_ent,
  input  logic                rm_en,
  input  logic [IDX_W-1:0]    rm_idx,
  input  ts_t                 cur_time,
  input  logic [WIN_W-1:0]    window,
  output popen_t [DEPTH-1:0]  ents,
  output logic   [DEPTH-1:0]  vld,
  output logic   [OCC_W-1:0]  occ,
  output logic                full,
  output logic                expired,
  output logic                dropped
);
  popen_t [DEPTH-1:0] ent_q, ent_n, ent_sh;
  logic   [OCC_W-1:0] occ_q, occ_mid, occ_n;
  logic               head_exp, do_rm, acc;
  logic   [IDX_W-1:0] rm_pos;
  ts_t                head_age;

  for (genvar i = 0; i < DEPTH; i++) begin : g_vld
    assign vld[i] = OCC_W'(i) < occ_q;
  end

  assign full     = (occ_q == OCC_W'(DEPTH));
  assign head_age = cur_time - ent_q[0].ts;
  assign head_exp = (occ_q != '0) && (head_age > TS_W'(window)) && !rm_en;
  assign do_rm    = rm_en || head_exp;
  assign rm_pos   = rm_en ? rm_idx : '0;
  assign acc      = push && !full;
  assign ent_sh   = ent_q >> $bits(popen_t);
  assign occ_mid  = occ_q - OCC_W'(do_rm);
  assign occ_n    = occ_mid + OCC_W'(acc);

  always_comb begin
    ent_n = ent_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (do_rm && i >= int'(rm_pos)) ent_n[i] = ent_sh[i];
    end
    if (acc) ent_n[occ_mid[IDX_W-1:0]] = push_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
      occ_q <= '0;
    end else begin
      ent_q <= ent_n;
      occ_q <= occ_n;
    end
  end

  assign ents    = ent_q;
  assign occ     = occ_q;
  assign expired = head_exp;
  assign dropped = push && full;
endmodule

// File: rtl/pe_evt_count.sv
module pe_evt_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + W'(1);
  end
endmodule

// File: rtl/pe_coinc_top.sv
module pe_coinc_top
  import pe_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   cur_time,
  input  logic [WIN_W-1:0]  win_ticks,
  input  logic              p_valid,
  output logic              p_ready,
  input  logic [PIX_W-1:0]  p_pixel,
  input  logic [TS_W-1:0]   p_time,
  input  logic              e_valid,
  output logic              e_ready,
  input  logic [PIX_W-1:0]  e_pixel,
  input  logic              e_plane,
  input  logic [TS_W-1:0]   e_time,
  input  logic              tbl_we,
  input  logic [PIX_W-1:0]  tbl_pixel,
  input  logic [SLOT_W-1:0] tbl_slot,
  input  logic [PIX_W-1:0]  tbl_nbr,
  output logic              c_valid,
  input  logic              c_ready,
  output logic [PIX_W-1:0]  c_p_pixel,
  output logic [PIX_W-1:0]  c_e_pixel,
  output logic              c_e_plane,
  output logic [TS_W-1:0]   c_dt,
  output logic [CNT_W-1:0]  n_coinc,
  output logic [CNT_W-1:0]  n_expired,
  output logic [CNT_W-1:0]  n_dropped
);
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W   = $clog2(DEPTH + 1);
  localparam int N_EVCNT = 3;

  popen_t [DEPTH-1:0]         ents;
  logic   [DEPTH-1:0]         vld;
  logic   [OCC_W-1:0]         occ;
  logic                       list_full, expired, dropped;
  logic [NNBR-1:0][PIX_W-1:0] nbr_row;
  logic                       hit_any, rm_en;
  logic   [IDX_W-1:0]         hit_idx;
  ts_t                        hit_dt;
  pix_t                       hit_pix;

  logic        out_v;
  pix_t        out_pp, out_ep;
  logic        out_pl;
  ts_t         out_dt;

  assign p_ready = 1'b1;
  assign e_ready = !out_v || c_ready;
  assign rm_en   = e_valid && e_ready && hit_any;

  pe_nbr_table u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_we),
    .wr_pix  (tbl_pixel),
    .wr_slot (tbl_slot),
    .wr_val  (tbl_nbr),
    .rd_pix  (e_pixel),
    .rd_nbrs (nbr_row)
  );

  pe_match_unit #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_match (
    .ents    (ents),
    .vld     (vld),
    .e_pix   (e_pixel),
    .e_ts    (e_time),
    .nbrs    (nbr_row),
    .window  (win_ticks),
    .hit_any (hit_any),
    .hit_idx (hit_idx),
    .hit_dt  (hit_dt),
    .hit_pix (hit_pix)
  );

  pe_open_list #(.DEPTH(DEPTH), .IDX_W(IDX_W), .OCC_W(OCC_W)) u_list (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (p_valid),
    .push_ent ('{pix: p_pixel, ts: p_time}),
    .rm_en    (rm_en),
    .rm_idx   (hit_idx),
    .cur_time (cur_time),
    .window   (win_ticks),
    .ents     (ents),
    .vld      (vld),
    .occ      (occ),
    .full     (list_full),
    .expired  (expired),
    .dropped  (dropped)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v  <= 1'b0;
      out_pp <= '0;
      out_ep <= '0;
      out_pl <= 1'b0;
      out_dt <= '0;
    end else if (rm_en) begin
      out_v  <= 1'b1;
      out_pp <= hit_pix;
      out_ep <= e_pixel;
      out_pl <= e_plane;
      out_dt <= hit_dt;
    end else if (c_ready) begin
      out_v  <= 1'b0;
    end
  end

  assign c_valid   = out_v;
  assign c_p_pixel = out_pp;
  assign c_e_pixel = out_ep;
  assign c_e_plane = out_pl;
  assign c_dt      = out_dt;

  logic [N_EVCNT-1:0] ev_inc;
  logic [CNT_W-1:0]   ev_cnt [N_EVCNT];
  assign ev_inc = {dropped, expired, rm_en};

  for (genvar k = 0; k < N_EVCNT; k++) begin : g_cnt
    pe_evt_count #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ev_inc[k]),
      .count (ev_cnt[k])
    );
  end

  assign n_coinc   = ev_cnt[0];
  assign n_expired = ev_cnt[1];
  assign n_dropped = ev_cnt[2];
endmodule

// File: rtl/pe_coinc_chk.sv
module pe_coinc_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 16,
  parameter int OCC_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             c_valid,
  input logic             c_ready,
  input logic [6:0]       c_p_pixel,
  input logic [6:0]       c_e_pixel,
  input logic             c_e_plane,
  input logic [31:0]      c_dt,
  input logic             e_ready,
  input logic             p_valid,
  input logic             list_full,
  input logic             rm_en,
  input logic [OCC_W-1:0] occ,
  input logic [CNT_W-1:0] n_coinc,
  input logic [CNT_W-1:0] n_dropped
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid && !c_ready |=> c_valid && $stable(c_p_pixel) && $stable(c_e_pixel) && $stable(c_e_plane) && $stable(c_dt)); // R6

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid && !c_ready |-> !e_ready); // R6

  AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH)); // R1

  AST_DROP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    p_valid && list_full |=> n_dropped == CNT_W'($past(n_dropped) + 1'b1)); // R2

  AST_PAIR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    rm_en |=> c_valid && n_coinc == CNT_W'($past(n_coinc) + 1'b1)); // R10
endmodule

bind pe_coinc_top pe_coinc_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .OCC_W(OCC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .c_valid   (c_valid),
  .c_ready   (c_ready),
  .c_p_pixel (c_p_pixel),
  .c_e_pixel (c_e_pixel),
  .c_e_plane (c_e_plane),
  .c_dt      (c_dt),
  .e_ready   (e_ready),
  .p_valid   (p_valid),
  .list_full (list_full),
  .rm_en     (rm_en),
  .occ       (occ),
  .n_coinc   (n_coinc),
  .n_dropped (n_dropped)
);

// File: tb/test_pe_coinc_top.sv
module test_pe_coinc_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cur_time = '0;
  logic [15:0] win_ticks = 16'd4000;
  logic        p_valid = 1'b0, e_valid = 1'b0, tbl_we = 1'b0, c_ready = 1'b1;
  logic        p_ready, e_ready, c_valid, c_e_plane, e_plane = 1'b0;
  logic [6:0]  p_pixel = '0, e_pixel = '0, tbl_pixel = '0, tbl_nbr = '0;
  logic [2:0]  tbl_slot = '0;
  logic [31:0] p_time = '0, e_time = '0, c_dt;
  logic [6:0]  c_p_pixel, c_e_pixel;
  logic [15:0] n_coinc, n_expired, n_dropped;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pe_coinc_top i_pe_coinc_top (
    .clk(clk), .rst_n(rst_n), .cur_time(cur_time), .win_ticks(win_ticks),
    .p_valid(p_valid), .p_ready(p_ready), .p_pixel(p_pixel), .p_time(p_time),
    .e_valid(e_valid), .e_ready(e_ready), .e_pixel(e_pixel), .e_plane(e_plane),
    .e_time(e_time), .tbl_we(tbl_we), .tbl_pixel(tbl_pixel), .tbl_slot(tbl_slot),
    .tbl_nbr(tbl_nbr), .c_valid(c_valid), .c_ready(c_ready), .c_p_pixel(c_p_pixel),
    .c_e_pixel(c_e_pixel), .c_e_plane(c_e_plane), .c_dt(c_dt), .n_coinc(n_coinc),
    .n_expired(n_expired), .n_dropped(n_dropped)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr_nbr(input int pix, input int slot, input int val);
    @(negedge clk);
    tbl_we = 1'b1; tbl_pixel = 7'(pix); tbl_slot = 3'(slot); tbl_nbr = 7'(val);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic do_reset(input int t0);
    @(negedge clk);
    rst_n = 1'b0; c_ready = 1'b1; win_ticks = 16'd4000; cur_time = 32'(t0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wr_nbr(11, 0, 10);
    wr_nbr(30, 5, 10);
  endtask

  task automatic send_p(input int pix, input int t);
    @(negedge clk);
    p_valid = 1'b1; p_pixel = 7'(pix); p_time = 32'(t);
    @(negedge clk);
    p_valid = 1'b0;
  endtask

  // returns at the falling edge after the accepting edge, when the result is visible
  task automatic send_e(input int pix, input logic pl, input int t);
    @(negedge clk);
    e_valid = 1'b1; e_pixel = 7'(pix); e_plane = pl; e_time = 32'(t);
    @(negedge clk);
    e_valid = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset(0);
    chk("R11", "c_valid", c_valid, 0);
    chk("R11", "n_coinc", n_coinc, 0);
    chk("R11", "n_expired", n_expired, 0);
    chk("R11", "n_dropped", n_dropped, 0);
    chk("R1", "p_ready", p_ready, 1);
    chk("R6", "e_ready idle", e_ready, 1);
    send_e(10, 1'b0, 50);
    chk("R11", "no pair on empty list", c_valid, 0);
  endtask

  task automatic t_same_pixel();
    do_reset(100);
    send_p(10, 100);
    send_e(10, 1'b0, 200);
    chk("R5", "c_valid", c_valid, 1);
    chk("R5", "c_p_pixel", c_p_pixel, 10);
    chk("R5", "c_e_pixel", c_e_pixel, 10);
    chk("R5", "c_e_plane", c_e_plane, 0);
    chk("R5", "c_dt", c_dt, 100);
    chk("R10", "n_coinc", n_coinc, 1);
    @(negedge clk);
    chk("R6", "c_valid drops when taken", c_valid, 0);
  endtask

  task automatic t_neighbour();
    do_reset(100);
    send_p(10, 100);
    send_e(11, 1'b1, 300);
    chk("R3", "neighbour pair valid", c_valid, 1);
    chk("R3", "bottom plane", c_e_plane, 1);
    chk("R3", "c_e_pixel", c_e_pixel, 11);
    chk("R3", "c_dt", c_dt, 200);
    send_p(10, 400);
    cur_time = 400;
    send_e(30, 1'b0, 450);
    chk("R9", "slot 5 neighbour", c_valid, 1);
    chk("R9", "slot 5 dt", c_dt, 50);
  endtask

  task automatic t_no_match();
    do_reset(100);
    send_p(10, 100);
    send_e(12, 1'b0, 150);
    chk("R7", "non-neighbour no pair", c_valid, 0);
    chk("R7", "n_coinc unchanged", n_coinc, 0);
    send_e(10, 1'b0, 160);
    chk("R7", "proton still open", c_valid, 1);
    chk("R7", "dt after miss", c_dt, 60);
  endtask

  task automatic t_window_edges();
    do_reset(1000);
    send_p(10, 1000);
    send_e(10, 1'b0, 5001);
    chk("R3", "one past window", c_valid, 0);
    send_e(10, 1'b0, 999);
    chk("R3", "electron before proton", c_valid, 0);
    send_e(10, 1'b0, 5000);
    chk("R3", "exactly window", c_valid, 1);
    chk("R3", "dt at edge", c_dt, 4000);
    do_reset(100);
    win_ticks = 16'd50;
    send_p(10, 100);
    send_e(10, 1'b0, 151);
    chk("R3", "short window outside", c_valid, 0);
    send_e(10, 1'b0, 150);
    chk("R3", "short window edge", c_valid, 1);
  endtask

  task automatic t_oldest_first();
    do_reset(200);
    send_p(10, 100);
    send_p(10, 200);
    send_e(10, 1'b0, 300);
    chk("R4", "oldest dt", c_dt, 200);
    send_e(10, 1'b0, 300);
    chk("R4", "second dt", c_dt, 100);
    send_e(10, 1'b0, 300);
    chk("R4", "closed protons gone", c_valid, 0);
    chk("R10", "n_coinc two", n_coinc, 2);
  endtask

  task automatic t_expiry();
    do_reset(1000);
    send_p(10, 1000);
    cur_time = 5000;
    repeat (2) @(negedge clk);
    chk("R8", "kept at equality", n_expired, 0);
    cur_time = 5001;
    @(negedge clk);
    chk("R8", "expired count", n_expired, 1);
    send_e(10, 1'b0, 5000);
    chk("R8", "expired proton no pair", c_valid, 0);
  endtask

  task automatic t_full();
    do_reset(100);
    for (int k = 0; k < 5; k++) send_p(20 + k, 100);
    chk("R2", "n_dropped", n_dropped, 1);
    send_e(24, 1'b0, 150);
    chk("R2", "dropped proton no pair", c_valid, 0);
    send_e(23, 1'b0, 150);
    chk("R1", "fourth proton open", c_valid, 1);
    chk("R1", "fourth pixel", c_p_pixel, 23);
  endtask

  task automatic t_backpressure();
    do_reset(100);
    c_ready = 1'b0;
    send_p(10, 100);
    send_p(10, 110);
    send_e(10, 1'b1, 150);
    chk("R6", "held valid", c_valid, 1);
    chk("R6", "e_ready low", e_ready, 0);
    repeat (3) @(negedge clk);
    chk("R6", "still valid", c_valid, 1);
    chk("R6", "dt held", c_dt, 50);
    chk("R6", "plane held", c_e_plane, 1);
    c_ready = 1'b1;
    @(negedge clk);
    chk("R6", "released", c_valid, 0);
    chk("R6", "e_ready back", e_ready, 1);
    chk("R10", "one pair", n_coinc, 1);
  endtask

  task automatic t_same_cycle();
    do_reset(100);
    @(negedge clk);
    p_valid = 1'b1; p_pixel = 7'd10; p_time = 32'd100;
    e_valid = 1'b1; e_pixel = 7'd10; e_plane = 1'b0; e_time = 32'd100;
    @(negedge clk);
    p_valid = 1'b0; e_valid = 1'b0;
    chk("R12", "same-cycle proton unseen", c_valid, 0);
    send_e(10, 1'b0, 120);
    chk("R12", "proton opened afterwards", c_valid, 1);
    chk("R12", "dt", c_dt, 20);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_same_pixel();
    t_neighbour();
    t_no_match();
    t_window_edges();
    t_oldest_first();
    t_expiry();
    t_full();
    t_backpressure();
    t_same_cycle();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule